// File: doc/BRIEF.md
# Power Controller Command Sequencer

This block runs one command transaction at a time towards a power-management microcontroller. It uses a byte-wide link with a request/acknowledge handshake as its transport. A request carries a byte count and up to 32 bytes, with byte 0 being the opcode. A small parameter table of per-opcode length rules decides how the request is framed. The send rule either fixes how many parameter bytes go out or asks for an explicit length byte after the opcode. The reply rule either fixes how many reply bytes come back or says that the first reply byte is the count.

A rising edge on the attention input means the microcontroller holds interrupt data. Whenever the sequencer is idle, that notification is served before any request. The sequencer sends the acknowledge opcode, reads back a count-prefixed block into a 32-byte buffer and presents it with a valid pulse.

Some requests are answered later through the interrupt path, not by a reply phase. Once such a request has been sent, further requests of that kind are held until the consumer reports that the reply arrived.

Top module: `cmdseq_top`

## Requirements
- R1: A request with a byte count of 0 completes with a `done` pulse, `done_len` 0 and `done_err` 0, and no byte transfer takes place.
- R2: The opcode (byte 0) is sent first. For an opcode whose send rule is -1, a byte equal to the count minus one is sent next. The parameter bytes 1 to count-1 then follow in index order.
- R3: A request is rejected with a `done` pulse, `done_err` 1 and no byte transfer in two cases: its count exceeds 32, or its opcode has a fixed send rule s and its count differs from s+1.
- R4: When the reply rule is 0, `done` (length 0) follows the last sent byte. When the reply rule is a fixed r > 0, exactly r bytes are received and each is shown on `rsp_byte` with an `rsp_valid` pulse. `done_len` is then r.
- R5: For a reply rule of -1, the first received byte is the count of bytes that follow, and that many are received. A count of 0 ends the transaction at once, and a count of 32 is accepted.
- R6: A received count above 32 ends the transaction at once. On the request path this gives `done_err` 1 with `done_len` 0; on the interrupt path it gives `intr_err` 1.
- R7: A rising edge on `attn` latches a pending flag. In the idle state a pending flag wins over any request: the block sends `ACK_OP` (default 0x78) and reads a count-prefixed block. It then pulses `intr_valid` with `intr_len`, and byte k sits at `intr_data[8k+:8]`. `done` and `intr_valid` never pulse in the same cycle.
- R8: A request marked `req_async` with a reply rule of 0 sets a waiting flag once sent. While that flag is set, a further `req_async` request keeps `req_ready` low and starts no transfer, until `async_clr` pulses.
- R9: Once `xfer_req` rises, it stays high with `xfer_dir` (1 = send) and `xfer_wdata` unchanged until `xfer_done`. `req_ready` is high only while no transfer is requested.
- R10: The default rule table holds these opcodes as (send, reply): 0x11 (1, 0), 0x3A (2, -1), 0x48 (0, 2) and 0x5C (0, -1). Every other opcode uses (-1, -1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_async | input | 1 | Request's answer arrives through the interrupt path |
| req_nbytes | input | 6 | Byte count including the opcode |
| req_bytes | input | 256 | Request bytes, byte i at [8i+:8] |
| attn | input | 1 | Attention line from the microcontroller, rising edge counts |
| async_clr | input | 1 | Pulse: the awaited asynchronous reply has arrived |
| xfer_req | output | 1 | A byte transfer is requested |
| xfer_dir | output | 1 | 1 = send `xfer_wdata`, 0 = receive |
| xfer_wdata | output | 8 | Byte to send |
| xfer_done | input | 1 | One-cycle pulse: current transfer complete |
| xfer_rdata | input | 8 | Received byte, valid with `xfer_done` |
| rsp_valid | output | 1 | Reply byte strobe |
| rsp_byte | output | 8 | Reply byte |
| done | output | 1 | Request finished |
| done_err | output | 1 | Request rejected or bad reply count |
| done_len | output | 6 | Number of reply bytes received |
| intr_valid | output | 1 | Interrupt block ready |
| intr_err | output | 1 | Interrupt count above 32 |
| intr_len | output | 6 | Interrupt byte count |
| intr_data | output | 256 | Interrupt buffer, byte k at [8k+:8] |

## Verification
The properties assume a well-behaved link. `xfer_done` pulses for one cycle, only while `xfer_req` is high, and `xfer_rdata` is meaningful only in that cycle. They also assume that every fixed reply length in the rule table is 32 or less. The link model in the stimulus answers each transfer only after seeing `xfer_req`, drops `xfer_done` after one cycle and supplies received bytes from a scripted stream. Requests stay valid and unchanged until the cycle in which they are taken.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int MAX_BYTES  = 32;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);
    localparam int BUF_W      = MAX_BYTES * 8;
    localparam int RULE_W     = 24;   // {opcode[7:0], send[7:0], reply[7:0]}
    localparam int DEF_RULE_N = 4;

    localparam logic [DEF_RULE_N*RULE_W-1:0] DEF_RULES = {
        24'h5C00FF, 24'h480002, 24'h3A02FF, 24'h110100
    };

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_IACK, ST_READ, ST_READI
    } seq_state_e;

    typedef struct packed {
        logic signed [7:0] snd;
        logic signed [7:0] rcv;
    } len_rule_t;

    localparam len_rule_t RULE_DEFAULT = '{snd: -8'sd1, rcv: -8'sd1};

    // True when the byte count fits the opcode's fixed send rule (or none applies).
    function automatic logic fixed_len_ok(len_rule_t r, logic [CNT_W-1:0] n);
        return (r.snd < 0) || (int'(n) == int'(r.snd) + 1);
    endfunction

endpackage

// File: rtl/cmdseq_rule_lut.sv
module cmdseq_rule_lut
    import cmdseq_pkg::*;
#(
    parameter int                       RULE_N     = DEF_RULE_N,
    parameter logic [RULE_N*RULE_W-1:0] RULE_TABLE = DEF_RULES
) (
    input  logic [7:0] opcode,
    output len_rule_t  rule
);

    logic [RULE_N-1:0] hit;

    for (genvar g = 0; g < RULE_N; g++) begin : g_match
        assign hit[g] = (RULE_TABLE[g*RULE_W+16 +: 8] == opcode);
    end

    always_comb begin
        rule = RULE_DEFAULT;
        for (int i = 0; i < RULE_N; i++) begin
            if (hit[i]) rule = len_rule_t'(RULE_TABLE[i*RULE_W +: 16]);
        end
    end

endmodule

// File: rtl/cmdseq_attn_latch.sv
module cmdseq_attn_latch (
    input  logic clk,
    input  logic rst,
    input  logic attn,
    input  logic clr,
    output logic pend
);

    logic attn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            attn_d <= 1'b0;
            pend   <= 1'b0;
        end else begin
            attn_d <= attn;
            if (attn && !attn_d) pend <= 1'b1;   // new edge wins over a clear
            else if (clr)        pend <= 1'b0;
        end
    end

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter logic [7:0]               ACK_OP     = 8'h78,
    parameter int                       RULE_N     = DEF_RULE_N,
    parameter logic [RULE_N*RULE_W-1:0] RULE_TABLE = DEF_RULES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_async,
    input  logic [CNT_W-1:0] req_nbytes,
    input  logic [BUF_W-1:0] req_bytes,
    input  logic             attn,
    input  logic             async_clr,
    output logic             xfer_req,
    output logic             xfer_dir,
    output logic [7:0]       xfer_wdata,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rdata,
    output logic             rsp_valid,
    output logic [7:0]       rsp_byte,
    output logic             done,
    output logic             done_err,
    output logic [CNT_W-1:0] done_len,
    output logic             intr_valid,
    output logic             intr_err,
    output logic [CNT_W-1:0] intr_len,
    output logic [BUF_W-1:0] intr_data
);

    seq_state_e       state_q;
    logic [BUF_W-1:0] cmd_q;
    logic [CNT_W-1:0] nb_q, idx_q, cnt_q, tgt_q;
    len_rule_t        rule_q, lut_rule;
    logic             async_q, len_sent_q, len_known_q, awaiting_q;
    logic             attn_pend, pend_clr, at_idle, accept, req_bad;
    logic             rd_is_len, rd_bad, rd_last;
    logic [CNT_W-1:0] rd_cnt_n, rd_tgt_n;

    cmdseq_rule_lut #(.RULE_N(RULE_N), .RULE_TABLE(RULE_TABLE)) u_lut (
        .opcode (req_bytes[7:0]),
        .rule   (lut_rule)
    );

    cmdseq_attn_latch u_attn (
        .clk  (clk),
        .rst  (rst),
        .attn (attn),
        .clr  (pend_clr),
        .pend (attn_pend)
    );

    assign at_idle   = (state_q == ST_IDLE);
    assign req_ready = at_idle && !attn_pend && !(req_async && awaiting_q);
    assign accept    = req_valid && req_ready;
    assign pend_clr  = at_idle && attn_pend;
    assign req_bad   = (req_nbytes > CNT_W'(MAX_BYTES)) || !fixed_len_ok(lut_rule, req_nbytes);

    // Receive-side next values for the byte arriving with xfer_done.
    always_comb begin
        rd_is_len = !len_known_q;
        rd_bad    = rd_is_len && (xfer_rdata > 8'(MAX_BYTES));
        rd_cnt_n  = rd_is_len ? cnt_q : cnt_q + 1'b1;
        rd_tgt_n  = rd_is_len ? xfer_rdata[CNT_W-1:0] : tgt_q;
        rd_last   = rd_bad || (rd_cnt_n >= rd_tgt_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cmd_q       <= '0;
            nb_q        <= '0;
            idx_q       <= '0;
            cnt_q       <= '0;
            tgt_q       <= '0;
            rule_q      <= RULE_DEFAULT;
            async_q     <= 1'b0;
            len_sent_q  <= 1'b0;
            len_known_q <= 1'b0;
            awaiting_q  <= 1'b0;
            xfer_req    <= 1'b0;
            xfer_dir    <= 1'b0;
            xfer_wdata  <= '0;
            rsp_valid   <= 1'b0;
            rsp_byte    <= '0;
            done        <= 1'b0;
            done_err    <= 1'b0;
            done_len    <= '0;
            intr_valid  <= 1'b0;
            intr_err    <= 1'b0;
            intr_len    <= '0;
            intr_data   <= '0;
        end else begin
            done       <= 1'b0;
            done_err   <= 1'b0;
            rsp_valid  <= 1'b0;
            intr_valid <= 1'b0;
            intr_err   <= 1'b0;
            if (async_clr) awaiting_q <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    if (attn_pend) begin
                        xfer_req   <= 1'b1;
                        xfer_dir   <= 1'b1;
                        xfer_wdata <= ACK_OP;
                        state_q    <= ST_IACK;
                    end else if (accept) begin
                        if (req_nbytes == '0 || req_bad) begin
                            done     <= 1'b1;
                            done_err <= (req_nbytes != '0);
                            done_len <= '0;
                        end else begin
                            cmd_q      <= req_bytes;
                            nb_q       <= req_nbytes;
                            rule_q     <= lut_rule;
                            async_q    <= req_async;
                            len_sent_q <= (lut_rule.snd >= 0);
                            idx_q      <= CNT_W'(1);
                            xfer_req   <= 1'b1;
                            xfer_dir   <= 1'b1;
                            xfer_wdata <= req_bytes[7:0];
                            state_q    <= ST_SEND;
                        end
                    end
                end
                ST_SEND: if (xfer_done) begin
                    if (!len_sent_q) begin
                        xfer_wdata <= 8'(nb_q - 1'b1);
                        len_sent_q <= 1'b1;
                    end else if (idx_q < nb_q) begin
                        xfer_wdata <= cmd_q[{idx_q[4:0], 3'b000} +: 8];
                        idx_q      <= idx_q + 1'b1;
                    end else if (rule_q.rcv == 0) begin
                        xfer_req <= 1'b0;
                        state_q  <= ST_IDLE;
                        done     <= 1'b1;
                        done_len <= '0;
                        if (async_q) awaiting_q <= 1'b1;
                    end else begin
                        xfer_dir    <= 1'b0;
                        state_q     <= ST_READ;
                        cnt_q       <= '0;
                        len_known_q <= (rule_q.rcv > 0);
                        tgt_q       <= rule_q.rcv[CNT_W-1:0];
                    end
                end
                ST_IACK: if (xfer_done) begin
                    xfer_dir    <= 1'b0;
                    state_q     <= ST_READI;
                    cnt_q       <= '0;
                    tgt_q       <= '0;
                    len_known_q <= 1'b0;
                end
                ST_READ, ST_READI: if (xfer_done) begin
                    cnt_q       <= rd_cnt_n;
                    tgt_q       <= rd_tgt_n;
                    len_known_q <= 1'b1;
                    if (!rd_is_len) begin
                        if (state_q == ST_READ) begin
                            rsp_valid <= 1'b1;
                            rsp_byte  <= xfer_rdata;
                        end else begin
                            intr_data[{cnt_q[4:0], 3'b000} +: 8] <= xfer_rdata;
                        end
                    end
                    if (rd_last) begin
                        xfer_req <= 1'b0;
                        state_q  <= ST_IDLE;
                        if (state_q == ST_READ) begin
                            done     <= 1'b1;
                            done_err <= rd_bad;
                            done_len <= rd_cnt_n;
                        end else begin
                            intr_valid <= 1'b1;
                            intr_err   <= rd_bad;
                            intr_len   <= rd_cnt_n;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk
    import cmdseq_pkg::*;
#(
    parameter logic [7:0] ACK_OP = 8'h78
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             req_async,
    input logic             xfer_req,
    input logic             xfer_dir,
    input logic [7:0]       xfer_wdata,
    input logic             xfer_done,
    input logic             done,
    input logic [CNT_W-1:0] done_len,
    input logic             intr_valid,
    input logic [CNT_W-1:0] intr_len,
    input logic             awaiting,
    input logic             pend,
    input logic             at_idle
);

    assert_xfer_hold_R9: assert property (@(posedge clk) disable iff (rst)
        xfer_req && !xfer_done |=> xfer_req && $stable(xfer_dir) && $stable(xfer_wdata));

    assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !xfer_req);

    assert_ack_first_R7: assert property (@(posedge clk) disable iff (rst)
        pend && at_idle |=> xfer_req && xfer_dir && (xfer_wdata == ACK_OP));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(done && intr_valid));

    assert_async_hold_R8: assert property (@(posedge clk) disable iff (rst)
        awaiting && req_async |-> !req_ready);

    assert_done_bound_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> done_len <= CNT_W'(MAX_BYTES));

    assert_intr_bound_R6: assert property (@(posedge clk) disable iff (rst)
        intr_valid |-> intr_len <= CNT_W'(MAX_BYTES));

endmodule

bind cmdseq_top cmdseq_chk #(.ACK_OP(ACK_OP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .req_async  (req_async),
    .xfer_req   (xfer_req),
    .xfer_dir   (xfer_dir),
    .xfer_wdata (xfer_wdata),
    .xfer_done  (xfer_done),
    .done       (done),
    .done_len   (done_len),
    .intr_valid (intr_valid),
    .intr_len   (intr_len),
    .awaiting   (awaiting_q),
    .pend       (attn_pend),
    .at_idle    (at_idle)
);

// File: tb/test_cmdseq_top.sv
module test_cmdseq_top;
    import cmdseq_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0, req_async = 1'b0;
    logic             req_ready;
    logic [CNT_W-1:0] req_nbytes = '0;
    logic [BUF_W-1:0] req_bytes = '0;
    logic             attn = 1'b0, async_clr = 1'b0;
    logic             xfer_req, xfer_dir, xfer_done;
    logic [7:0]       xfer_wdata, xfer_rdata;
    logic             rsp_valid, done, done_err, intr_valid, intr_err;
    logic [7:0]       rsp_byte;
    logic [CNT_W-1:0] done_len, intr_len;
    logic [BUF_W-1:0] intr_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_tx[$];
    logic [7:0] rx_src[$];
    logic [6:0] exp_done[$];
    string      exp_done_tag[$];
    logic [7:0] exp_rsp[$];
    logic [6:0] exp_intr[$];
    logic [7:0] exp_ib[$];

    always #4 clk = ~clk;

    cmdseq_top i_cmdseq_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_async(req_async), .req_nbytes(req_nbytes), .req_bytes(req_bytes),
        .attn(attn), .async_clr(async_clr), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
        .xfer_wdata(xfer_wdata), .xfer_done(xfer_done), .xfer_rdata(xfer_rdata),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .done(done), .done_err(done_err),
        .done_len(done_len), .intr_valid(intr_valid), .intr_err(intr_err),
        .intr_len(intr_len), .intr_data(intr_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_done(input bit err, input int len, input string tag);
        exp_done.push_back({err, 6'(len)});
        exp_done_tag.push_back(tag);
    endtask

    // Link model: answers each transfer after a short delay (R9 stability, R2 order).
    initial begin
        xfer_done  = 1'b0;
        xfer_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst && xfer_req) begin
                logic       d;
                logic [7:0] w;
                logic [7:0] e;
                d = xfer_dir;
                w = xfer_wdata;
                repeat (2) @(negedge clk);
                chk(xfer_req && xfer_dir == d && xfer_wdata == w, "R9", "held transfer",
                    int'(xfer_wdata), int'(w));
                if (d) begin
                    if (exp_tx.size() == 0) chk(1'b0, "R2", "unexpected sent byte", int'(w), -1);
                    else begin
                        e = exp_tx.pop_front();
                        chk(w == e, "R2", "sent byte", int'(w), int'(e));
                    end
                end else begin
                    if (rx_src.size() == 0) begin
                        chk(1'b0, "R4", "unexpected receive", 0, -1);
                        xfer_rdata = '0;
                    end else xfer_rdata = rx_src.pop_front();
                end
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
            end
        end
    end

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (exp_done.size() == 0) chk(1'b0, "R1", "unexpected done", int'(done_len), -1);
                else begin
                    logic [6:0] ed;
                    string      t;
                    ed = exp_done.pop_front();
                    t  = exp_done_tag.pop_front();
                    chk({done_err, done_len} == ed, t, "done {err,len}",
                        int'({done_err, done_len}), int'(ed));
                end
            end
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) chk(1'b0, "R4", "unexpected reply byte", int'(rsp_byte), -1);
                else begin
                    logic [7:0] er;
                    er = exp_rsp.pop_front();
                    chk(rsp_byte == er, "R4", "reply byte", int'(rsp_byte), int'(er));
                end
            end
            if (intr_valid) begin
                if (exp_intr.size() == 0) chk(1'b0, "R7", "unexpected interrupt block", int'(intr_len), -1);
                else begin
                    logic [6:0] ei;
                    ei = exp_intr.pop_front();
                    chk({intr_err, intr_len} == ei, "R7", "intr {err,len}",
                        int'({intr_err, intr_len}), int'(ei));
                    for (int k = 0; k < int'(intr_len); k++) begin
                        logic [7:0] eb;
                        eb = (exp_ib.size() != 0) ? exp_ib.pop_front() : 8'h00;
                        chk(intr_data[k*8 +: 8] == eb, "R7", "intr byte", int'(intr_data[k*8 +: 8]), int'(eb));
                    end
                end
            end
        end
    end

    task automatic submit(input bit as, input int n, input logic [BUF_W-1:0] b);
        @(negedge clk);
        req_valid  = 1'b1;
        req_async  = as;
        req_nbytes = CNT_W'(n);
        req_bytes  = b;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_async = 1'b0;
    endtask

    task automatic drain();
        while (exp_tx.size() || rx_src.size() || exp_done.size() || exp_rsp.size() || exp_intr.size())
            @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic watch_quiet(input int n, input string tag);
        bit seen;
        seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (xfer_req) seen = 1'b1;
        end
        chk(!seen, tag, "no transfer expected", int'(seen), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [BUF_W-1:0] rb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready after reset", int'(req_ready), 1);
        chk(xfer_req == 1'b0, "R9", "no transfer after reset", int'(xfer_req), 0);
        chk(done == 1'b0 && intr_valid == 1'b0, "R7", "no pulses after reset", int'({done, intr_valid}), 0);

        // R1: empty request
        push_done(1'b0, 0, "R1");
        rb = '0; rb[7:0] = 8'h11;
        submit(1'b0, 0, rb);
        watch_quiet(6, "R1");
        drain();

        // R2/R4: fixed send 1, reply 0
        exp_tx.push_back(8'h11); exp_tx.push_back(8'hA5);
        push_done(1'b0, 0, "R4");
        rb = '0; rb[7:0] = 8'h11; rb[15:8] = 8'hA5;
        submit(1'b0, 2, rb);
        drain();

        // R3: count mismatch against fixed send rule
        push_done(1'b1, 0, "R3");
        rb = '0; rb[7:0] = 8'h11;
        submit(1'b0, 3, rb);
        watch_quiet(6, "R3");
        drain();

        // R3: count above 32
        push_done(1'b1, 0, "R3");
        rb = '0; rb[7:0] = 8'h80;
        submit(1'b0, 33, rb);
        watch_quiet(6, "R3");
        drain();

        // R2/R5/R10: unlisted opcode, length byte inserted, prefixed reply
        exp_tx.push_back(8'h80); exp_tx.push_back(8'h03);
        exp_tx.push_back(8'hC1); exp_tx.push_back(8'hC2); exp_tx.push_back(8'hC3);
        rx_src.push_back(8'h02); rx_src.push_back(8'hD1); rx_src.push_back(8'hD2);
        exp_rsp.push_back(8'hD1); exp_rsp.push_back(8'hD2);
        push_done(1'b0, 2, "R5");
        rb = '0; rb[7:0] = 8'h80; rb[15:8] = 8'hC1; rb[23:16] = 8'hC2; rb[31:24] = 8'hC3;
        submit(1'b0, 4, rb);
        drain();

        // R4: fixed reply of two bytes
        exp_tx.push_back(8'h48);
        rx_src.push_back(8'hE1); rx_src.push_back(8'hE2);
        exp_rsp.push_back(8'hE1); exp_rsp.push_back(8'hE2);
        push_done(1'b0, 2, "R4");
        rb = '0; rb[7:0] = 8'h48;
        submit(1'b0, 1, rb);
        drain();

        // R10/R5: fixed send 2 with no length byte, reply count 0
        exp_tx.push_back(8'h3A); exp_tx.push_back(8'h11); exp_tx.push_back(8'h22);
        rx_src.push_back(8'h00);
        push_done(1'b0, 0, "R10");
        rb = '0; rb[7:0] = 8'h3A; rb[15:8] = 8'h11; rb[23:16] = 8'h22;
        submit(1'b0, 3, rb);
        drain();

        // R6: reply count 33 aborts
        exp_tx.push_back(8'h5C);
        rx_src.push_back(8'h21);
        push_done(1'b1, 0, "R6");
        rb = '0; rb[7:0] = 8'h5C;
        submit(1'b0, 1, rb);
        drain();

        // R5: largest request and largest reply
        rb = '0; rb[7:0] = 8'h90;
        exp_tx.push_back(8'h90); exp_tx.push_back(8'h1F);
        for (int i = 1; i < 32; i++) begin
            rb[i*8 +: 8] = 8'(i * 3 + 1);
            exp_tx.push_back(8'(i * 3 + 1));
        end
        rx_src.push_back(8'h20);
        for (int i = 0; i < 32; i++) begin
            rx_src.push_back(8'(8'h40 + i));
            exp_rsp.push_back(8'(8'h40 + i));
        end
        push_done(1'b0, 32, "R5");
        submit(1'b0, 32, rb);
        drain();

        // R7: interrupt service from idle
        exp_tx.push_back(8'h78);
        rx_src.push_back(8'h03); rx_src.push_back(8'hF1); rx_src.push_back(8'hF2); rx_src.push_back(8'hF3);
        exp_intr.push_back({1'b0, 6'd3});
        exp_ib.push_back(8'hF1); exp_ib.push_back(8'hF2); exp_ib.push_back(8'hF3);
        @(negedge clk); attn = 1'b1;
        repeat (2) @(negedge clk); attn = 1'b0;
        drain();

        // R7: pending interrupt served before the next queued request
        exp_tx.push_back(8'h48);
        rx_src.push_back(8'h71); rx_src.push_back(8'h72);
        exp_rsp.push_back(8'h71); exp_rsp.push_back(8'h72);
        push_done(1'b0, 2, "R7");
        exp_tx.push_back(8'h78);
        rx_src.push_back(8'h01); rx_src.push_back(8'h99);
        exp_intr.push_back({1'b0, 6'd1});
        exp_ib.push_back(8'h99);
        exp_tx.push_back(8'h11); exp_tx.push_back(8'h5A);
        push_done(1'b0, 0, "R7");
        rb = '0; rb[7:0] = 8'h48;
        submit(1'b0, 1, rb);
        repeat (2) @(negedge clk); attn = 1'b1;
        @(negedge clk); attn = 1'b0;
        rb = '0; rb[7:0] = 8'h11; rb[15:8] = 8'h5A;
        submit(1'b0, 2, rb);
        drain();

        // R8: asynchronous request blocks the next one until cleared
        exp_tx.push_back(8'h11); exp_tx.push_back(8'h01);
        push_done(1'b0, 0, "R8");
        rb = '0; rb[7:0] = 8'h11; rb[15:8] = 8'h01;
        submit(1'b1, 2, rb);
        drain();
        exp_tx.push_back(8'h11); exp_tx.push_back(8'h02);
        push_done(1'b0, 0, "R8");
        @(negedge clk);
        req_valid = 1'b1; req_async = 1'b1; req_nbytes = CNT_W'(2);
        req_bytes = '0; req_bytes[7:0] = 8'h11; req_bytes[15:8] = 8'h02;
        repeat (12) begin
            @(negedge clk);
            chk(req_ready == 1'b0 && xfer_req == 1'b0, "R8", "held while awaiting",
                int'({req_ready, xfer_req}), 0);
        end
        async_clr = 1'b1;
        @(negedge clk); async_clr = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk); req_valid = 1'b0; req_async = 1'b0;
        drain();

        chk(exp_tx.size() == 0 && rx_src.size() == 0, "R2", "scoreboard empty",
            exp_tx.size() + rx_src.size(), 0);
        chk(exp_done.size() == 0 && exp_intr.size() == 0, "R4", "results all seen",
            exp_done.size() + exp_intr.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule